// File: doc/BRIEF.md
# PTP Transmit Timestamp Pad Writeback

This unit sits next to a descriptor-driven Ethernet transmit path. For each frame the fetch logic offers one descriptor pair: the first descriptor points at an 8-byte frame control block, and the second describes the frame data. The unit keeps the pair. It then watches the outgoing byte stream and, on the start-of-frame delimiter byte, captures a free-running 64-bit timer.

The captured value always goes into the transmit timestamp registers, together with the frame's identifier. When the global pad-record enable is set and the control block's PTP flag is set, the unit also writes the value to memory. It writes two 32-bit beats into the padding area that follows the control block: the upper word at the control block pointer plus 16, then the lower word at plus 20. Only after the last beat has been accepted does the unit close the second descriptor. It can also raise a frame-done interrupt at that point.

If the pair breaks the programming rules, the unit skips the pad write and flags an error with the close. The rules are that the control-block-present bit must be set, and that the data length must equal the frame length or exceed the transmit threshold.

Top module: `ptp_tx_stamp_wb`

## Requirements
- R1: After reset the unit is idle: `desc_ready` is 1, `mem_wvalid`, `bd_close`, `irq_txf` and `ts_evt` are 0, and `ts_hi`, `ts_lo` and `ts_id` are 0.
- R2: The first `tx_data` byte equal to 8'hAB while `tx_valid` is 1 is the timestamp point. Preamble bytes (8'h55) are not. At that point `timer_now[63:32]` goes to `ts_hi`, `timer_now[31:0]` goes to `ts_lo` and the pair's frame ID goes to `ts_id`, and `ts_evt` pulses for one cycle. This happens whether or not pad writeback takes place.
- R3: Pad writeback happens only when `cfg_pad_en`, `desc_ptp` and `desc_cb_here` are all 1 and the length rule holds. It takes exactly two beats: `ts_hi` at `desc_cb_ptr`+16, then `ts_lo` at `desc_cb_ptr`+20.
- R4: With `cfg_pad_en` = 0, no memory beat is issued, and the descriptor still closes.
- R5: A beat keeps `mem_wvalid`, `mem_waddr` and `mem_wdata` unchanged until `mem_wready` is 1.
- R6: `bd_close` pulses for one cycle. When writeback takes place, the pulse comes in the cycle after the second beat is accepted, and never while `mem_wvalid` is 1.
- R7: `irq_txf` is 1 only together with `bd_close`, and only when the pair's `desc_irq_en` was 1.
- R8: With `desc_cb_here` = 0, no beat is written, and `bd_err` is 1 during the close pulse.
- R9: The length rule holds when `desc_data_len` equals `desc_frame_len` or is strictly greater than `cfg_tx_thresh`. A length equal to the threshold and not equal to the frame length breaks the rule: no beat is written and `bd_err` is 1 at close.
- R10: From acceptance until close, `desc_ready` is 0, and any other pair offered in that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pad_en | input | 1 | Global enable for timestamp writeback into the pad area |
| cfg_tx_thresh | input | LW | Transmit threshold used by the length rule |
| desc_valid | input | 1 | A descriptor pair is offered |
| desc_ready | output | 1 | The unit can take a pair |
| desc_cb_ptr | input | AW | First descriptor's buffer pointer (start of the control block) |
| desc_cb_here | input | 1 | First descriptor's control-block-present bit |
| desc_ptp | input | 1 | PTP flag from the control block |
| desc_data_len | input | LW | Second descriptor's data length |
| desc_frame_len | input | LW | Full frame length |
| desc_irq_en | input | 1 | Second descriptor's interrupt request bit |
| desc_frame_id | input | IDW | Identifier stored with the timestamp |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| timer_now | input | 64 | Free-running timer: seconds in the upper word, nanoseconds in the lower word |
| mem_wvalid | output | 1 | Memory write beat valid |
| mem_waddr | output | AW | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_wready | input | 1 | Memory accepts the beat |
| bd_close | output | 1 | One-cycle close strobe for the second descriptor |
| bd_err | output | 1 | Programming-rule error, valid together with bd_close |
| irq_txf | output | 1 | Frame-done interrupt pulse |
| ts_hi | output | 32 | Timestamp register, upper word |
| ts_lo | output | 32 | Timestamp register, lower word |
| ts_id | output | IDW | Timestamp register, frame ID |
| ts_evt | output | 1 | One-cycle pulse when the timestamp registers are loaded |

## Verification
Each frame sends preamble bytes with a deliberately wrong timer value, then the delimiter with the expected value. A latch on the wrong byte therefore shows up in both the registers and the memory beats. The enable, PTP-flag, control-block and length inputs are each cleared on their own. This separates a missing gate from a wrong error decision, and the threshold case checks equal-versus-greater. A run where the memory holds each beat for three cycles tells a held handshake from one that moves on, and shows whether the close waits for the second acceptance. A pair offered while the unit is busy shows whether it is dropped or taken.

// File: rtl/ptp_tx_stamp_wb.sv
module ptp_tx_stamp_wb #(
  parameter int AW      = 32,
  parameter int LW      = 16,
  parameter int IDW     = 16,
  parameter int PAD_OFS = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_pad_en,
  input  logic [LW-1:0]  cfg_tx_thresh,
  input  logic           desc_valid,
  output logic           desc_ready,
  input  logic [AW-1:0]  desc_cb_ptr,
  input  logic           desc_cb_here,
  input  logic           desc_ptp,
  input  logic [LW-1:0]  desc_data_len,
  input  logic [LW-1:0]  desc_frame_len,
  input  logic           desc_irq_en,
  input  logic [IDW-1:0] desc_frame_id,
  input  logic           tx_valid,
  input  logic [7:0]     tx_data,
  input  logic [63:0]    timer_now,
  output logic           mem_wvalid,
  output logic [AW-1:0]  mem_waddr,
  output logic [31:0]    mem_wdata,
  input  logic           mem_wready,
  output logic           bd_close,
  output logic           bd_err,
  output logic           irq_txf,
  output logic [31:0]    ts_hi,
  output logic [31:0]    ts_lo,
  output logic [IDW-1:0] ts_id,
  output logic           ts_evt
);

  localparam logic [7:0]    SFD     = 8'hAB;
  localparam logic [AW-1:0] OFS_HI  = AW'(PAD_OFS);
  localparam logic [AW-1:0] OFS_LO  = AW'(PAD_OFS + 4);

  typedef enum logic [2:0] {S_IDLE, S_SFD, S_HI, S_LO, S_CLOSE} st_t;

  st_t            st;
  logic [AW-1:0]  ptr_q;
  logic [IDW-1:0] id_q;
  logic           irq_q, err_q, wb_q;

  wire len_ok  = (desc_data_len == desc_frame_len) || (desc_data_len > cfg_tx_thresh);
  wire take    = desc_valid && desc_ready;
  wire sfd_hit = (st == S_SFD) && tx_valid && (tx_data == SFD);

  assign desc_ready = (st == S_IDLE);
  assign mem_wvalid = (st == S_HI) || (st == S_LO);
  assign mem_waddr  = ptr_q + ((st == S_LO) ? OFS_LO : OFS_HI);
  assign mem_wdata  = (st == S_LO) ? ts_lo : ts_hi;
  assign bd_close   = (st == S_CLOSE);
  assign bd_err     = bd_close && err_q;
  assign irq_txf    = bd_close && irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr_q  <= '0;
      id_q   <= '0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
      wb_q   <= 1'b0;
      ts_hi  <= '0;
      ts_lo  <= '0;
      ts_id  <= '0;
      ts_evt <= 1'b0;
    end else begin
      ts_evt <= 1'b0;
      unique case (st)
        S_IDLE: if (take) begin
          ptr_q <= desc_cb_ptr;
          id_q  <= desc_frame_id;
          irq_q <= desc_irq_en;
          err_q <= !desc_cb_here || !len_ok;
          wb_q  <= cfg_pad_en && desc_ptp && desc_cb_here && len_ok;
          st    <= S_SFD;
        end
        S_SFD: if (sfd_hit) begin
          ts_hi  <= timer_now[63:32];
          ts_lo  <= timer_now[31:0];
          ts_id  <= id_q;
          ts_evt <= 1'b1;
          st     <= wb_q ? S_HI : S_CLOSE;
        end
        S_HI:    if (mem_wready) st <= S_LO;
        S_LO:    if (mem_wready) st <= S_CLOSE;
        S_CLOSE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata));

  // R6
  close_vs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bd_close && mem_wvalid));

  // R6
  close_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bd_close |=> !bd_close);

  // R7
  irq_with_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txf |-> bd_close);

  // R4
  no_write_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> cfg_pad_en);

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready |=> !desc_ready);

endmodule

// File: tb/ptp_tx_stamp_wb_tb.sv
`timescale 1ns/1ps
module ptp_tx_stamp_wb_tb_top;
  localparam int AW = 32, LW = 16, IDW = 16;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic           cfg_pad_en = 0, desc_valid = 0, desc_cb_here = 0, desc_ptp = 0, desc_irq_en = 0;
  logic [LW-1:0]  cfg_tx_thresh = 16'd64, desc_data_len = 0, desc_frame_len = 0;
  logic [AW-1:0]  desc_cb_ptr = 0;
  logic [IDW-1:0] desc_frame_id = 0;
  logic           tx_valid = 0, mem_wready = 1;
  logic [7:0]     tx_data = 0;
  logic [63:0]    timer_now = 0;
  logic           desc_ready, mem_wvalid, bd_close, bd_err, irq_txf, ts_evt;
  logic [AW-1:0]  mem_waddr;
  logic [31:0]    mem_wdata, ts_hi, ts_lo;
  logic [IDW-1:0] ts_id;

  ptp_tx_stamp_wb #(.AW(AW), .LW(LW), .IDW(IDW)) dut_i (.*);

  int checks = 0, errors = 0;
  int cyc = 0, beats = 0, close_cyc = -1, evts = 0, hold = 0, stall_n = 0;
  logic [AW-1:0] b_addr [2];
  logic [31:0]   b_data [2];
  int            b_cyc [2];
  logic          c_err, c_irq, closed;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_wvalid && mem_wready) begin
      if (beats < 2) begin b_addr[beats] = mem_waddr; b_data[beats] = mem_wdata; b_cyc[beats] = cyc; end
      beats = beats + 1;
      hold = 0;
    end
    if (ts_evt) evts = evts + 1;
    if (bd_close) begin closed = 1; close_cyc = cyc; c_err = bd_err; c_irq = irq_txf; end
  end

  always @(negedge clk) begin
    if (mem_wvalid && hold < stall_n) begin mem_wready = 0; hold = hold + 1; end
    else mem_wready = 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual %0h expected %0h", req, act, exp); end
  endtask

  task automatic clear_log();
    beats = 0; evts = 0; closed = 0; close_cyc = -1; c_err = 0; c_irq = 0; hold = 0;
  endtask

  task automatic run_frame(input logic [AW-1:0] ptr, input bit cb, input bit ptp,
                           input logic [LW-1:0] dlen, input logic [LW-1:0] flen,
                           input bit irq, input logic [IDW-1:0] id, input logic [63:0] stamp,
                           input bit busy_test);
    clear_log();
    @(negedge clk);
    desc_cb_ptr = ptr; desc_cb_here = cb; desc_ptp = ptp; desc_data_len = dlen;
    desc_frame_len = flen; desc_irq_en = irq; desc_frame_id = id; desc_valid = 1;
    @(negedge clk);
    desc_valid = 0;
    timer_now = ~stamp;
    for (int i = 0; i < 3; i++) begin
      tx_valid = 1; tx_data = 8'h55;
      @(negedge clk);
      if (busy_test && i == 0) begin
        chk(desc_ready == 0, "R10 ready while busy", desc_ready, 0);
        desc_cb_ptr = ptr + 32'h1000; desc_frame_id = id + 1; desc_valid = 1;
      end else desc_valid = 0;
    end
    desc_valid = 0;
    tx_valid = 0; @(negedge clk);
    timer_now = stamp; tx_valid = 1; tx_data = 8'hAB;
    @(negedge clk);
    tx_valid = 0; tx_data = 8'h00; timer_now = ~stamp;
    for (int i = 0; i < 40 && !closed; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(desc_ready == 1, "R1 ready", desc_ready, 1);
    chk(mem_wvalid == 0 && bd_close == 0 && irq_txf == 0 && ts_evt == 0, "R1 strobes", {mem_wvalid, bd_close, irq_txf, ts_evt}, 0);
    chk(ts_hi == 0 && ts_lo == 0 && ts_id == 0, "R1 ts regs", {ts_hi, ts_lo}, 0);
  endtask

  task automatic t_basic();
    logic [63:0] s = 64'h0000_1234_89AB_CDEF;
    cfg_pad_en = 1; stall_n = 0;
    run_frame(32'h100, 1, 1, 100, 100, 1, 16'h0A5, s, 0);
    chk(ts_hi == s[63:32] && ts_lo == s[31:0], "R2 ts value", {ts_hi, ts_lo}, s);
    chk(ts_id == 16'h0A5 && evts == 1, "R2 id/evt", {ts_id, 16'(evts)}, {16'h0A5, 16'd1});
    chk(beats == 2, "R3 beat count", beats, 2);
    chk(b_addr[0] == 32'h110 && b_data[0] == s[63:32], "R3 beat0", {b_addr[0], b_data[0]}, {32'h110, s[63:32]});
    chk(b_addr[1] == 32'h114 && b_data[1] == s[31:0], "R3 beat1", {b_addr[1], b_data[1]}, {32'h114, s[31:0]});
    chk(close_cyc == b_cyc[1] + 1, "R6 close after last beat", close_cyc, b_cyc[1] + 1);
    chk(c_irq == 1 && c_err == 0, "R7 irq at close", {c_irq, c_err}, 2'b10);
  endtask

  task automatic t_stall();
    logic [63:0] s = 64'h0000_0042_0000_7777;
    cfg_pad_en = 1; stall_n = 3;
    run_frame(32'h2000, 1, 1, 80, 90, 0, 16'h7, s, 0);
    stall_n = 0;
    chk(beats == 2 && b_data[0] == s[63:32] && b_data[1] == s[31:0], "R5 data under stall", {b_data[0], b_data[1]}, s);
    chk(b_addr[1] == 32'h2014, "R5 addr under stall", b_addr[1], 32'h2014);
    chk(close_cyc == b_cyc[1] + 1, "R6 close after stalled beat", close_cyc, b_cyc[1] + 1);
    chk(closed && c_irq == 0, "R7 no irq when bit clear", c_irq, 0);
  endtask

  task automatic t_disabled();
    logic [63:0] s = 64'hDEAD_0001_BEEF_0002;
    cfg_pad_en = 0;
    run_frame(32'h300, 1, 1, 100, 100, 1, 16'h3, s, 0);
    chk(beats == 0 && closed, "R4 no write, still closes", {beats[7:0], 7'd0, closed}, 1);
    chk(ts_lo == s[31:0] && evts == 1, "R2 regs updated without writeback", ts_lo, s[31:0]);
    cfg_pad_en = 1;
  endtask

  task automatic t_noptp();
    run_frame(32'h400, 1, 0, 100, 100, 0, 16'h4, 64'h5, 0);
    chk(beats == 0 && closed && c_err == 0, "R3 PTP flag clear", beats, 0);
  endtask

  task automatic t_nocb();
    run_frame(32'h500, 0, 1, 100, 100, 1, 16'h5, 64'h6, 0);
    chk(beats == 0, "R8 no write without control block", beats, 0);
    chk(closed && c_err == 1 && c_irq == 1, "R8 error at close", {c_err, c_irq}, 2'b11);
  endtask

  task automatic t_len();
    cfg_tx_thresh = 16'd64;
    run_frame(32'h600, 1, 1, 64, 100, 0, 16'h6, 64'h7, 0);
    chk(beats == 0 && closed && c_err == 1, "R9 len equal to threshold", {beats[7:0], c_err}, 9'h001);
    run_frame(32'h700, 1, 1, 65, 100, 0, 16'h8, 64'h9, 0);
    chk(beats == 2 && c_err == 0, "R9 len above threshold", {beats[7:0], c_err}, 9'h004);
  endtask

  task automatic t_busy();
    run_frame(32'h800, 1, 1, 100, 100, 0, 16'h20, 64'hAA_0000_00BB, 1);
    chk(beats == 2 && b_addr[0] == 32'h810 && ts_id == 16'h20, "R10 busy offer ignored", b_addr[0], 32'h810);
    repeat (4) @(negedge clk);
    chk(closed == 1 && evts == 1 && desc_ready == 1, "R10 no second frame taken", evts, 1);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_stall();
    t_disabled();
    t_noptp();
    t_nocb();
    t_len();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule